// File: doc/BRIEF.md
# Serial channel-load sequencer

This block drives the two-wire serial port that loads a channel number into a radio's synthesizer. A host gives it a channel value and a one-cycle start request. The block then produces the whole framed waveform on a clock line and a data line. The frame opens with a start condition: clock high and data low. Eight data bits follow, least significant first. Each bit is placed on the data line while the clock is low and held through the next clock-high phase. The frame closes with both lines high, which makes the radio latch the value. After that the block keeps both lines high for a mandatory idle gap before another frame may begin.

Every duration is a minimum with no upper bound. Each one is given as a parameter in nanoseconds and converted to system clock cycles, rounding up. The latch hold is stretched automatically when the phases alone would make the frame shorter than the minimum packet time. A request that arrives during the idle gap is held and served as soon as the gap expires. A request for a channel above the maximum is refused with a one-cycle error pulse, and no frame is sent.

Top module: `chsel_loader`

## Requirements
- R1: After reset both lines are high, busy is high, and done and error are low. The first frame can begin no earlier than GAP cycles after reset is released.
- R2: A frame begins with clock at 1 and data at 0, held for START cycles. Busy rises in the same cycle the start condition first appears.
- R3: Each bit has a clock-low phase of exactly LOW cycles followed by a clock-high phase of exactly HIGH cycles.
- R4: The eight bits go out with bit 0 first and bit 7 last. The data line holds a bit's value across its whole low and high phase.
- R5: After the eighth high phase both lines are 1 for LATCH cycles. LATCH is the larger of the latch minimum and the frame minimum minus START+8*(LOW+HIGH).
- R6: Done is 1 for exactly one cycle, the cycle right after the latch hold ends. Both lines stay 1 from then on.
- R7: After each frame, busy stays 1 for GAP cycles, counted from the done cycle, and then falls. A request made during the gap (including the done cycle and the gap's last cycle) is sent as a new frame at once when the gap expires, without busy falling.
- R8: A start request made while a frame is being sent has no effect: the frame is unchanged and no second frame follows it.
- R9: A channel value above MAX_CHAN (100) is refused. Error is 1 for one cycle, busy stays 0 and both lines stay 1. A value of 100 is accepted. A refused request that was held during a gap raises error when the gap expires.
- R10: Every duration in cycles is its nanosecond parameter divided by the clock period, rounded up, with a minimum of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to load chan_i |
| chan_i | input | NBITS | Channel number to load |
| sclk_o | output | 1 | Serial clock line to the radio |
| sdat_o | output | 1 | Serial data line to the radio |
| busy_o | output | 1 | High while a frame or idle gap is in progress |
| done_o | output | 1 | One-cycle pulse after the latch hold |
| err_o | output | 1 | One-cycle pulse when a channel value is refused |

## Verification
Two events can fall in the same cycle: the end of the idle gap and a new start request, or a held request. The bench provokes this in three ways. It raises a request in the done cycle. It raises one in the gap's very last cycle, so the request meets gap expiry on the same edge. It also holds an out-of-range request through a gap. In the first two cases the next frame's start condition must appear exactly GAP cycles after done, with busy never falling. In the third case, error must pulse in that same cycle with the lines left high. A request made in the middle of a frame is checked against the undisturbed waveform, and busy must then fall on time with no second frame.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

   typedef enum logic [2:0] {
      ST_GAP,
      ST_IDLE,
      ST_START,
      ST_LOW,
      ST_HIGH,
      ST_LATCH
   } seq_st_t;

   // nanoseconds to whole clock cycles, rounded up, never below one
   function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
      int unsigned c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned umax(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/chsel_timer.sv
module chsel_timer #(
   parameter int unsigned CW      = 16,
   parameter int unsigned RST_VAL = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] ld_val,
   output logic          zero
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= CW'(RST_VAL);
      else if (load)
         cnt <= ld_val;
      else if (cnt != '0)
         cnt <= cnt - CW'(1);
   end

   assign zero = (cnt == '0);

   // R3: a running phase counts down by exactly one per cycle
   a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

endmodule

// File: rtl/chsel_shift.sv
module chsel_shift #(
   parameter int unsigned NBITS     = 8,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [NBITS-1:0] din,
   input  logic             step,
   output logic             bit_o,
   output logic             last_o
);

   localparam int unsigned IW = (NBITS > 1) ? $clog2(NBITS) : 1;

   logic [NBITS-1:0] sh;
   logic [IW-1:0]    idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx <= '0;
      else if (load)
         idx <= '0;
      else if (step)
         idx <= idx + IW'(1);
   end

   generate
      if (LSB_FIRST) begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sh <= '0;
            else if (load)
               sh <= din;
            else if (step)
               sh <= sh >> 1;
         end
         assign bit_o = sh[0];
      end else begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sh <= '0;
            else if (load)
               sh <= din;
            else if (step)
               sh <= sh << 1;
         end
         assign bit_o = sh[NBITS-1];
      end
   endgenerate

   assign last_o = (idx == IW'(NBITS - 1));

   // R4: the bit index never runs past the last bit of the frame
   a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (idx <= IW'(NBITS - 1)));

endmodule

// File: rtl/chsel_loader.sv
module chsel_loader
   import chsel_pkg::*;
#(
   parameter int unsigned NBITS     = 8,
   parameter int unsigned MAX_CHAN  = 100,
   parameter bit          LSB_FIRST = 1'b1,
   parameter int unsigned CLK_NS    = 20,
   parameter int unsigned GAP_NS    = 1_000_000,
   parameter int unsigned START_NS  = 25_000,
   parameter int unsigned LOW_NS    = 5_000,
   parameter int unsigned HIGH_NS   = 8_000,
   parameter int unsigned LATCH_NS  = 5_000,
   parameter int unsigned PKT_NS    = 157_000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [NBITS-1:0] chan_i,
   output logic             sclk_o,
   output logic             sdat_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o
);

   localparam int unsigned GAP_C    = ns_to_cyc(GAP_NS, CLK_NS);
   localparam int unsigned START_C  = ns_to_cyc(START_NS, CLK_NS);
   localparam int unsigned LOW_C    = ns_to_cyc(LOW_NS, CLK_NS);
   localparam int unsigned HIGH_C   = ns_to_cyc(HIGH_NS, CLK_NS);
   localparam int unsigned LMIN_C   = ns_to_cyc(LATCH_NS, CLK_NS);
   localparam int unsigned PKT_C    = ns_to_cyc(PKT_NS, CLK_NS);
   localparam int unsigned BODY_C   = START_C + NBITS * (LOW_C + HIGH_C);
   localparam int unsigned LATCH_C  = (PKT_C > BODY_C + LMIN_C) ? (PKT_C - BODY_C) : LMIN_C;
   localparam int unsigned MAXC     = umax(umax(GAP_C, START_C), umax(umax(LOW_C, HIGH_C), LATCH_C));
   localparam int unsigned CW       = $clog2(MAXC + 1);
   localparam logic [NBITS-1:0] MAXV = NBITS'(MAX_CHAN);

   generate
      if (NBITS < 2) begin : g_bad_width
         $error("chsel_loader: NBITS must be at least 2");
      end
      if (MAX_CHAN >= (1 << NBITS)) begin : g_bad_max
         $error("chsel_loader: MAX_CHAN does not fit in NBITS");
      end
      if (CLK_NS == 0) begin : g_bad_clk
         $error("chsel_loader: CLK_NS must be non-zero");
      end
   endgenerate

   seq_st_t          st, nxt;
   logic             tz, ld, go, bad, step, fin, bit_v, last_v;
   logic [CW-1:0]    ldv;
   logic [NBITS-1:0] go_ch, pend_ch;
   logic             pend, err_r, done_r;

   chsel_timer #(.CW(CW), .RST_VAL(GAP_C - 1)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(ld), .ld_val(ldv), .zero(tz)
   );

   chsel_shift #(.NBITS(NBITS), .LSB_FIRST(LSB_FIRST)) u_shf (
      .clk(clk), .rst_n(rst_n), .load(go && !bad), .din(go_ch),
      .step(step), .bit_o(bit_v), .last_o(last_v)
   );

   always_comb begin
      nxt   = st;
      ld    = 1'b0;
      ldv   = '0;
      go    = 1'b0;
      go_ch = chan_i;
      step  = 1'b0;
      fin   = 1'b0;
      case (st)
         ST_GAP: if (tz) begin
            if (pend) begin
               go    = 1'b1;
               go_ch = pend_ch;
            end else if (start_i) begin
               go = 1'b1;
            end else begin
               nxt = ST_IDLE;
            end
         end
         ST_IDLE: if (start_i) go = 1'b1;
         ST_START: if (tz) begin
            nxt = ST_LOW;  ld = 1'b1; ldv = CW'(LOW_C - 1);
         end
         ST_LOW: if (tz) begin
            nxt = ST_HIGH; ld = 1'b1; ldv = CW'(HIGH_C - 1);
         end
         ST_HIGH: if (tz) begin
            ld = 1'b1;
            if (last_v) begin
               nxt = ST_LATCH; ldv = CW'(LATCH_C - 1);
            end else begin
               nxt = ST_LOW;   ldv = CW'(LOW_C - 1); step = 1'b1;
            end
         end
         ST_LATCH: if (tz) begin
            nxt = ST_GAP; ld = 1'b1; ldv = CW'(GAP_C - 1); fin = 1'b1;
         end
         default: nxt = ST_IDLE;
      endcase
      bad = go && (go_ch > MAXV);
      if (go) begin
         if (bad) begin
            nxt = ST_IDLE;
         end else begin
            nxt = ST_START; ld = 1'b1; ldv = CW'(START_C - 1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_GAP;
         pend    <= 1'b0;
         pend_ch <= '0;
         err_r   <= 1'b0;
         done_r  <= 1'b0;
      end else begin
         st     <= nxt;
         err_r  <= bad;
         done_r <= fin;
         if (st != ST_GAP || tz) begin
            pend <= 1'b0;
         end else if (start_i) begin
            pend    <= 1'b1;
            pend_ch <= chan_i;
         end
      end
   end

   always_comb begin
      case (st)
         ST_START: begin sclk_o = 1'b1; sdat_o = 1'b0;  end
         ST_LOW:   begin sclk_o = 1'b0; sdat_o = bit_v; end
         ST_HIGH:  begin sclk_o = 1'b1; sdat_o = bit_v; end
         default:  begin sclk_o = 1'b1; sdat_o = 1'b1;  end
      endcase
   end

   assign busy_o = (st != ST_IDLE);
   assign done_o = done_r;
   assign err_o  = err_r;

   // R6: done never lasts longer than one cycle
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R7: done appears inside the gap with both lines released high
   a_r7_done_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (busy_o && sclk_o && sdat_o));
   // R9: a refused request leaves the block idle and the lines high
   a_r9_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!busy_o && sclk_o && sdat_o && !done_o));
   // R2: leaving idle always shows the start condition first
   a_r2_start_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (sclk_o && !sdat_o));
   // R4: data holds still across the rising clock of each bit
   a_r4_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HIGH) |-> $stable(sdat_o));

endmodule

// File: tb/chsel_loader_test.sv
module chsel_loader_test;

   // R10: 20 ns clock; 400->20, 110->6, 50->3, 70->4, 50->3, 1390->70 cycles
   localparam int S  = 6;
   localparam int L  = 3;
   localparam int H  = 4;
   localparam int G  = 20;
   localparam int LT = 8;                  // R5: max(3, 70 - (6 + 8*7))
   localparam int T  = S + 8 * (L + H) + LT;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] chan_i = 8'd0;
   logic       sclk_o, sdat_o, busy_o, done_o, err_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   chsel_loader #(
      .NBITS(8), .MAX_CHAN(100), .LSB_FIRST(1'b1), .CLK_NS(20),
      .GAP_NS(400), .START_NS(110), .LOW_NS(50), .HIGH_NS(70),
      .LATCH_NS(50), .PKT_NS(1390)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
      .sclk_o(sclk_o), .sdat_o(sdat_o), .busy_o(busy_o),
      .done_o(done_o), .err_o(err_o)
   );

   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // expected {sclk, sdat} at cycle k of a frame carrying ch
   function automatic logic [1:0] exp_lines(input logic [7:0] ch, input int k);
      int r;
      int i;
      if (k < S) return 2'b10;
      r = k - S;
      if (r < 8 * (L + H)) begin
         i = r / (L + H);
         r = r % (L + H);
         return (r < L) ? {1'b0, ch[i]} : {1'b1, ch[i]};
      end
      return 2'b11;
   endfunction

   // called at the negedge where the start condition is first visible
   task automatic take_packet(input logic [7:0] ch, input int inj_k, input logic [7:0] inj_ch);
      int lmiss = 0, dmiss = 0, bmiss = 0;
      int la = 0, le = 0;
      for (int k = 0; k < T + G; k++) begin
         if ({sclk_o, sdat_o} !== exp_lines(ch, k)) begin
            if (lmiss == 0) begin la = {sclk_o, sdat_o}; le = exp_lines(ch, k); end
            lmiss++;
         end
         if (done_o !== (k == T)) dmiss++;
         if (busy_o !== 1'b1 || err_o !== 1'b0) bmiss++;
         if (k == inj_k) begin start_i = 1'b1; chan_i = inj_ch; end
         else start_i = 1'b0;
         @(negedge clk);
      end
      start_i = 1'b0;
      chk(lmiss == 0, "R2/R3/R4/R5 frame lines", la, le);
      chk(dmiss == 0, "R6 done pulse position", dmiss, 0);
      chk(bmiss == 0, "R7 busy through frame and gap", bmiss, 0);
   endtask

   task automatic send(input logic [7:0] ch, input int inj_k, input logic [7:0] inj_ch);
      start_i = 1'b1;
      chan_i  = ch;
      @(negedge clk);
      start_i = 1'b0;
      take_packet(ch, inj_k, inj_ch);
   endtask

   task automatic chk_idle(input string tag);
      chk(busy_o === 1'b0 && sclk_o === 1'b1 && sdat_o === 1'b1 && done_o === 1'b0 && err_o === 1'b0,
          tag, {busy_o, sclk_o, sdat_o, done_o, err_o}, 5'b01100);
   endtask

   task automatic reject(input logic [7:0] ch);
      start_i = 1'b1;
      chan_i  = ch;
      @(negedge clk);
      start_i = 1'b0;
      chk(err_o === 1'b1 && busy_o === 1'b0 && sclk_o === 1'b1 && sdat_o === 1'b1,
          "R9 refusal pulse", {err_o, busy_o, sclk_o, sdat_o}, 4'b1011);
      @(negedge clk);
      chk_idle("R9 refusal ends, lines untouched");
      repeat (3) @(negedge clk);
      chk_idle("R9 still idle after refusal");
   endtask

   initial begin
      int held_ok;
      logic [7:0] rc;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n   = 1'b1;
      chk(busy_o === 1'b1 && sclk_o === 1'b1 && sdat_o === 1'b1 && done_o === 1'b0 && err_o === 1'b0,
          "R1 reset state", {busy_o, sclk_o, sdat_o, done_o, err_o}, 5'b11100);
      start_i = 1'b1;
      chan_i  = 8'd45;
      @(negedge clk);
      start_i = 1'b0;
      held_ok = 1;
      for (int j = 1; j < G; j++) begin
         if (sdat_o !== 1'b1 || sclk_o !== 1'b1 || busy_o !== 1'b1) held_ok = 0;
         @(negedge clk);
      end
      chk(held_ok == 1, "R1 initial gap holds request", held_ok, 1);
      take_packet(8'd45, -1, 8'd0);
      chk_idle("R7 busy falls after gap");

      send(8'd100, -1, 8'd0);             // R9 boundary accepted
      chk_idle("R9 channel 100 accepted");
      send(8'd0, -1, 8'd0);
      chk_idle("R4 all-zero channel");
      send(8'd85, 20, 8'd3);              // R8 request mid-frame
      chk_idle("R8 mid-frame request ignored");
      @(negedge clk);
      chk_idle("R8 no second frame");

      send(8'd99, T, 8'd77);              // R7 request in done cycle
      take_packet(8'd77, T + G - 1, 8'd9); // R7 request in last gap cycle
      take_packet(8'd9, -1, 8'd0);
      chk_idle("R7 back-to-back frames end idle");

      reject(8'd101);
      reject(8'd255);

      send(8'd64, T + 3, 8'd200);         // R9 refused request held in gap
      chk(err_o === 1'b1 && busy_o === 1'b0, "R9 held refusal at gap end",
          {err_o, busy_o}, 2'b10);
      @(negedge clk);
      chk_idle("R9 held refusal sends nothing");

      for (int n = 0; n < 10; n++) begin
         rc = 8'($urandom_range(0, 120));
         if (rc > 8'd100) reject(rc);
         else begin
            send(rc, -1, 8'd0);
            chk_idle("R4 random channel frame ends idle");
         end
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #3_000_000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog R1 actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule